// File: doc/BRIEF.md
# Fractional Baud Prescaler

This block sits between a clock source and the baud-rate divider of a serial interface. It divides its input clock by a whole number from 1 to 8. It can also add a fine adjustment in steps of 1/32. Its output, `tick`, is an enable that is high for one input-clock cycle each time an output period ends. A later divider counts these ticks.

An 8-bit control register sets the division:

- The upper three bits pick the whole-number divisor.
- The lower five bits give an insertion count N.

Output periods are grouped into frames of 32. Within each frame, exactly N periods are one input clock longer than the base period. The long periods are spread over the frame in the way a phase accumulator spreads them, so they do not bunch together. The average divisor is therefore PD + N/32.

Select code 0 is the bypass mode. In bypass, the input clock passes straight through as a tick on every cycle, and the insertion count is ignored.

The register is written through a one-cycle write strobe and can be read back at any time. A written value does not change the period already under way. The block reads the register at each tick, and that value sets the length of the period that starts after the tick.

The controller has three named states:

- **ST_BYPASS**: a tick on every cycle.
- **ST_COUNT**: counts the base period down to zero. It ticks on the last cycle unless that period is to be stretched.
- **ST_INSERT**: the one inserted clock of a stretched period. It always ticks.

Transitions happen on every tick:

- To ST_BYPASS when the select code held in the register is 0.
- Otherwise to ST_COUNT, with the counter loaded to the select code.

There is one further transition. ST_COUNT goes to ST_INSERT when its counter reaches zero and the stretch flag of the current period is set.

Top module: `fpsc_top`

## Requirements
- R1: The control register is 8 bits wide. Bits [7:5] hold the divisor select code and bits [4:0] hold the insertion count N. A cycle with `cfg_we` high loads `cfg_wdata`, and the new value appears on `cfg_rdata` from the next cycle. When `cfg_we` is low, the register holds its value.
- R2: While reset is low, and right after reset, the register reads 0 and the block is in bypass. `tick` is high on every cycle.
- R3: A select code c from 1 to 7 gives a base period of PD = c + 1 input clocks between ticks. With N = 0, every period is exactly c + 1 clocks long. A tick is never followed by a tick on the next cycle.
- R4: Select code 0 makes `tick` high on every input clock, whatever the value of N.
- R5: In every frame of 32 output periods with a stable non-bypass setting, the 32 period lengths add up to exactly 32·PD + N.
- R6: Ticks are counted from reset, and the first tick after reset is number 1. The period that starts after tick number t has frame index k = t mod 32. That period lasts PD + 1 clocks when ((k·N) mod 32) + N ≥ 32, and PD clocks otherwise.
- R7: The register value held during a tick cycle sets the length of the next period. A write made during a period does not change that period's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Write data: [7:5] select code, [4:0] insertion count |
| cfg_rdata | output | 8 | Current control register value |
| tick | output | 1 | One-cycle enable at the end of each output period |

## Verification
A wrong state, counter or stretch flag shows up on `tick` within one output period, at most nine input clocks. That period is then shorter or longer than its expected length, and the first mismatched tick interval exposes it. A wrong frame counter does not change period lengths when N is 0. With a non-zero N, it moves the stretched periods to other frame indices, so the interval checks that follow catch it. The frame-sum check then catches it within 32 periods. A register fault shows on `cfg_rdata` one cycle after the write.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_COUNT  = 2'd1,
        ST_INSERT = 2'd2
    } fpsc_state_e;

    // Default field widths
    localparam int unsigned SEL_W_DEF  = 3;
    localparam int unsigned FRAC_W_DEF = 5;

endpackage

// File: rtl/fpsc_cfg_reg.sv
module fpsc_cfg_reg #(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_o)); // R1

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> cfg_o == $past(wdata_i)); // R1

endmodule

// File: rtl/fpsc_spread.sv
module fpsc_spread #(
    parameter int unsigned FRAC_W = 5
) (
    input  logic [FRAC_W-1:0] idx_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              stretch_o
);

    localparam int unsigned PROD_W = 2 * FRAC_W;

    logic [PROD_W-1:0] prod;
    logic [FRAC_W-1:0] phase;
    logic [FRAC_W:0]   sum;

    // The phase reached before period idx equals idx*N modulo the frame length.
    // Adding N to it carries out exactly N times over one frame.
    always_comb begin
        prod      = PROD_W'(idx_i) * PROD_W'(frac_i);
        phase     = prod[FRAC_W-1:0];
        sum       = {1'b0, phase} + {1'b0, frac_i};
        stretch_o = sum[FRAC_W];
    end

endmodule

// File: rtl/fpsc_fsm.sv
module fpsc_fsm
    import fpsc_pkg::*;
#(
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              stretch_i,
    output logic [FRAC_W-1:0] idx_next_o,
    output logic              tick_o
);

    fpsc_state_e       state_q, state_d;
    logic [SEL_W-1:0]  cnt_q, cnt_d;
    logic              str_q, str_d;
    logic [FRAC_W-1:0] frame_q, frame_d;
    logic              tick_w;

    assign idx_next_o = frame_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            cnt_q   <= '0;
            str_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            str_q   <= str_d;
            frame_q <= frame_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_BYPASS: tick_w = 1'b1;
            ST_COUNT:  tick_w = (cnt_q == '0) && !str_q;
            ST_INSERT: tick_w = 1'b1;
            default:   tick_w = 1'b0;
        endcase
    end

    assign tick_o = tick_w;

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        str_d   = str_q;
        frame_d = frame_q;
        unique case (state_q)
            ST_BYPASS: state_d = ST_BYPASS;
            ST_COUNT: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (str_q) begin
                    state_d = ST_INSERT;
                end
            end
            ST_INSERT: state_d = ST_INSERT;
            default:   state_d = ST_BYPASS;
        endcase
        if (tick_w) begin
            frame_d = idx_next_o;
            if (sel_i == '0) begin
                state_d = ST_BYPASS;
                cnt_d   = '0;
                str_d   = 1'b0;
            end else begin
                state_d = ST_COUNT;
                cnt_d   = sel_i;
                str_d   = stretch_i;
            end
        end
    end

    AST_INSERT_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_INSERT |-> $past(state_q) == ST_COUNT); // R6

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_w |=> frame_q == $past(frame_q) + 1'b1); // R6

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !tick_w && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
    import fpsc_pkg::*;
#(
    parameter int unsigned SEL_W  = SEL_W_DEF,
    parameter int unsigned FRAC_W = FRAC_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W+FRAC_W-1:0]   cfg_wdata,
    output logic [SEL_W+FRAC_W-1:0]   cfg_rdata,
    output logic                      tick
);

    localparam int unsigned CFG_W = SEL_W + FRAC_W;

    logic [CFG_W-1:0]  cfg;
    logic [SEL_W-1:0]  sel;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W-1:0] idx_next;
    logic              stretch;

    assign sel  = cfg[CFG_W-1:FRAC_W];
    assign frac = cfg[FRAC_W-1:0];

    fpsc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    fpsc_spread #(.FRAC_W(FRAC_W)) u_spread (
        .idx_i     (idx_next),
        .frac_i    (frac),
        .stretch_o (stretch)
    );

    fpsc_fsm #(.SEL_W(SEL_W), .FRAC_W(FRAC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .stretch_i  (stretch),
        .idx_next_o (idx_next),
        .tick_o     (tick)
    );

    assign cfg_rdata = cfg;

    AST_BYPASS_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == '0) |=> tick); // R4

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> !tick); // R3

endmodule

// File: tb/tb_fpsc_top.sv
module tb_fpsc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    int        cyc = 0;
    int        ticks = 0;
    int        last_tick = 0;
    bit        have_prev = 1'b0;
    int        exp_len = 1;
    int        prev_k = 0;
    logic [7:0] prev_cfg = 8'h00;
    logic [7:0] model_reg = 8'h00;
    bit        wrote_in_period = 1'b0;
    int        fsum = 0;
    bit        fok = 1'b0;
    logic [7:0] fcfg = 8'h00;

    always #2 clk = ~clk;

    fpsc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick      (tick)
    );

    function automatic int period_len(input logic [7:0] c, input int k);
        int pd;
        int n;
        pd = int'(c[7:5]) + 1;
        n  = int'(c[4:0]);
        if (c[7:5] == 3'd0) return 1;
        return pd + ((((k * n) % 32) + n) >= 32 ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Sample one cycle's outputs and advance the model
    task automatic observe();
        int iv;
        check(cfg_rdata == model_reg, "R1", int'(cfg_rdata), int'(model_reg));
        if (tick) begin
            if (have_prev) begin
                iv = cyc - last_tick;
                if (wrote_in_period)
                    check(iv == exp_len, "R7", iv, exp_len);
                else if (prev_cfg[7:5] == 3'd0)
                    check(iv == exp_len, "R4", iv, exp_len);
                else if (prev_cfg[4:0] == 5'd0)
                    check(iv == exp_len, "R3", iv, exp_len);
                else
                    check(iv == exp_len, "R6", iv, exp_len);
                // Frame sum (R5)
                if (prev_k == 0) begin
                    fsum = 0;
                    fok  = 1'b1;
                    fcfg = prev_cfg;
                end
                fsum += iv;
                if (prev_cfg != fcfg) fok = 1'b0;
                if (prev_k == 31 && fok && fcfg[7:5] != 3'd0)
                    check(fsum == 32 * (int'(fcfg[7:5]) + 1) + int'(fcfg[4:0]), "R5",
                          fsum, 32 * (int'(fcfg[7:5]) + 1) + int'(fcfg[4:0]));
            end
            ticks++;
            prev_k    = ticks % 32;
            prev_cfg  = model_reg;
            exp_len   = period_len(model_reg, prev_k);
            last_tick = cyc;
            have_prev = 1'b1;
            wrote_in_period = 1'b0;
        end else if (have_prev && (cyc - last_tick) >= exp_len) begin
            check(1'b0, "R6", cyc - last_tick, exp_len);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] d);
        @(negedge clk);
        cyc++;
        observe();
        if (cfg_we) wrote_in_period = 1'b1;
        cfg_we    = we;
        cfg_wdata = d;
        if (we) model_reg = d;
    endtask

    always @(posedge clk) begin
        if (!done && cyc > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            done = 1'b1;
            $finish;
        end
    end

    initial begin
        int nlist[10];
        nlist = '{0, 1, 2, 3, 7, 15, 16, 17, 30, 31};
        repeat (3) @(negedge clk);
        // R2: reset state
        check(cfg_rdata == 8'h00, "R2", int'(cfg_rdata), 0);
        check(tick == 1'b1, "R2", int'(tick), 1);
        rst_n = 1'b1;
        #1;
        // First cycle after reset
        check(tick == 1'b1, "R2", int'(tick), 1);
        observe();
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 8'h00);
            check(tick == 1'b1, "R2", int'(tick), 1);
        end
        // Sweep codes and insertion counts
        for (int c = 0; c < 8; c++) begin
            for (int j = 0; j < 10; j++) begin
                int start;
                step(1'b1, {3'(c), 5'(nlist[j])});
                start = ticks;
                while (ticks < start + 70) step(1'b0, 8'h00);
            end
        end
        // R7: write in the middle of a long period
        step(1'b1, 8'hE0);
        begin
            int s;
            s = ticks;
            while (ticks < s + 3) step(1'b0, 8'h00);
        end
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        step(1'b1, 8'h20);
        begin
            int s;
            s = ticks;
            while (ticks < s + 6) step(1'b0, 8'h00);
        end
        // R4: bypass ignores a non-zero insertion count
        step(1'b1, 8'h1F);
        begin
            int s;
            s = ticks;
            while (ticks < s + 3) step(1'b0, 8'h00);
            for (int i = 0; i < 8; i++) begin
                step(1'b0, 8'h00);
                check(tick == 1'b1, "R4", int'(tick), 1);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule